// File: doc/BRIEF.md
# Split-Line Instruction Fetch Aligner

This block is the read side of a two-way set-associative instruction cache with 32-byte lines and 128 sets. It hands the prefetch queue a 16-byte window that begins at any byte address. Instructions are between one and fifteen bytes long, so one instruction can start near the end of a line and finish in the following line. A fetch whose offset falls in the upper half of a line therefore reads two lines in the same clock through two lookup ports. The upper 16 bytes come from the addressed line and the lower 16 bytes from the line that follows it. The merged bytes are then rotated into ascending address order.

Both lookups check tag and valid state in each way, so the two halves may sit in different ways. The response carries a separate miss flag for each line. Each 8-byte group of a line keeps one even-parity bit, and every group that feeds the window is checked. A window is marked good only when every line it touches hits and none of its groups shows a parity mismatch. A plain line-write port loads line contents, tag and parity bits directly into a chosen way and set. Line fill, victim choice and coherence snooping belong to other blocks.

Top module: `ifa_split_fetch`

## Requirements
- R1: The fetch address is split into a byte offset (bits 4:0), a set index (bits 11:5) and a tag (bits 31:12). A line hits when some way of its set holds it valid with an equal tag. A write on the line-write port stores data, tag and the four parity bits in the given way and set and marks that entry valid, replacing whatever entry was there. Reset marks every entry invalid.
- R2: A fetch request sampled at a clock edge produces a one-cycle respValid pulse after that edge, with all response outputs updated at the same time. The response outputs keep their values until the next request, and writes do not change them.
- R3: When offset bit 4 is 0, only the addressed line is used. Window byte i, placed at fetchBytes bits 8i+7:8i, is line byte offset+i, and splitAccess is 0.
- R4: When offset bit 4 is 1, the access is split and splitAccess is 1. Window byte i is the byte at address fetchAddr+i, taken from bytes 16..31 of the addressed line followed by bytes 0..15 of the next line.
- R5: The second line of a split access is the line at address+32. A split access that starts in set 127 therefore looks up set 0 with the tag plus one.
- R6: fetchValid is 1 only when every line the access touches hits and no checked parity group mismatches.
- R7: missN is 1 when the addressed line misses. missN1 is 1 only for a split access whose second line misses, and it is never set by a non-split access.
- R8: Stored parity bit k covers line bytes 8k..8k+7 with even parity, meaning the bit equals the XOR of those 64 data bits. A mismatch in any group that overlaps the 16 delivered bytes sets parityError, but only when all touched lines hit. A mismatch in a group that is not delivered is ignored.
- R9: The two halves of a split access may hit in different ways of their respective sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchReq | input | 1 | Fetch request strobe |
| fetchAddr | input | 32 | Byte address of the first window byte |
| wrEn | input | 1 | Line-write strobe |
| wrWay | input | 1 | Way to write |
| wrIndex | input | 7 | Set to write |
| wrTag | input | 20 | Tag stored with the written line |
| wrLine | input | 256 | Line data, byte 0 in bits 7:0 |
| wrParity | input | 4 | Parity bits stored with the line, bit k for bytes 8k..8k+7 |
| respValid | output | 1 | Response pulse, one cycle after a request |
| fetchValid | output | 1 | Window is complete and parity-clean |
| missN | output | 1 | Addressed line missed |
| missN1 | output | 1 | Next line of a split access missed |
| parityError | output | 1 | A delivered parity group mismatched |
| splitAccess | output | 1 | Response came from two lines |
| fetchBytes | output | 128 | Window bytes in ascending address order |

## Verification
A wrong rotation amount or a swapped half shows up as misordered bytes in the response that follows the request by one cycle. The vectors therefore cover offsets at both ends of each half of a line. A wrong next-line index or tag, for example a failure to carry into the tag when crossing set 127, shows up in that same response as a false missN1 or as bytes from a decoy line placed in set 0. A parity group mask that is off by one shows up as a parityError that appears or is missing on a line that was loaded with a deliberately corrupted group.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
  localparam int LINE_BYTES  = 32;
  localparam int GROUP_BYTES = 8;
  localparam int HALF_BYTES  = LINE_BYTES / 2;
  localparam int OFF_W       = $clog2(LINE_BYTES);
  localparam int ROT_W       = OFF_W - 1;
  localparam int GROUPS      = LINE_BYTES / GROUP_BYTES;
  localparam int HALF_GROUPS = GROUPS / 2;
  localparam int LINE_BITS   = LINE_BYTES * 8;
  localparam int WIN_BITS    = HALF_BYTES * 8;
  localparam int GROUP_BITS  = GROUP_BYTES * 8;

  // strobes from control to datapath
  typedef struct packed {
    logic                capture;
    logic                split;
    logic [ROT_W-1:0]    rot;
    logic [GROUPS-1:0]   groupUse;
    logic                write;
  } ifaCtl_t;

  function automatic logic [GROUPS-1:0] groupParity(input logic [LINE_BITS-1:0] bytesIn);
    logic [GROUPS-1:0] p;
    for (int g = 0; g < GROUPS; g++) p[g] = ^bytesIn[g*GROUP_BITS +: GROUP_BITS];
    return p;
  endfunction
endpackage

// File: rtl/ifa_way_match.sv
module ifa_way_match
  import ifa_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int TAG_W = 20
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [WAYS-1:0]                 wayValid,
  input  logic [WAYS-1:0][TAG_W-1:0]      wayTag,
  input  logic [TAG_W-1:0]                tagIn,
  input  logic [WAYS-1:0][LINE_BITS-1:0]  wayLine,
  input  logic [WAYS-1:0][GROUPS-1:0]     wayPar,
  output logic                            hit,
  output logic [LINE_BITS-1:0]            line,
  output logic [GROUPS-1:0]               par
);
  logic [WAYS-1:0] match;

  // lowest matching way wins
  always_comb begin
    hit  = 1'b0;
    line = '0;
    par  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      match[w] = wayValid[w] && (wayTag[w] == tagIn);
      if (match[w]) begin
        hit  = 1'b1;
        line = wayLine[w];
        par  = wayPar[w];
      end
    end
  end

  assert_unique_way_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(match))
    else $error("two ways hold the same line");
endmodule

// File: rtl/ifa_ctrl.sv
module ifa_ctrl
  import ifa_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchReq,
  input  logic [OFF_W-1:0] fetchOffset,
  input  logic             wrEn,
  output ifaCtl_t          ctl,
  output logic             respValid
);
  always_comb begin
    ctl.capture = fetchReq;
    ctl.split   = fetchOffset[OFF_W-1];
    ctl.rot     = fetchOffset[ROT_W-1:0];
    ctl.write   = wrEn;
    // a group is checked when it overlaps bytes rot..rot+HALF_BYTES-1 of the merged buffer
    for (int k = 0; k < GROUPS; k++) begin
      ctl.groupUse[k] = (k * GROUP_BYTES <= int'(fetchOffset[ROT_W-1:0]) + HALF_BYTES - 1) &&
                        (k * GROUP_BYTES + GROUP_BYTES - 1 >= int'(fetchOffset[ROT_W-1:0]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= fetchReq;
  end

  assert_group_span_R8: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> ($countones(ctl.groupUse) >= HALF_BYTES / GROUP_BYTES &&
                  $countones(ctl.groupUse) <= HALF_BYTES / GROUP_BYTES + 1))
    else $error("parity group mask spans a wrong number of groups");
endmodule

// File: rtl/ifa_datapath.sv
module ifa_datapath
  import ifa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128,
  parameter int WAYS   = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int LA_W  = ADDR_W - OFF_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ifaCtl_t              ctl,
  input  logic [LA_W-1:0]      lineAddr,
  input  logic [WAY_W-1:0]     wrWay,
  input  logic [IDX_W-1:0]     wrIndex,
  input  logic [TAG_W-1:0]     wrTag,
  input  logic [LINE_BITS-1:0] wrLine,
  input  logic [GROUPS-1:0]    wrParity,
  output logic [WIN_BITS-1:0]  fetchBytes,
  output logic                 fetchValid,
  output logic                 missN,
  output logic                 missN1,
  output logic                 parityError,
  output logic                 splitAccess
);
  logic [LINE_BITS-1:0] dataMem [WAYS][SETS];
  logic [TAG_W-1:0]     tagMem  [WAYS][SETS];
  logic [GROUPS-1:0]    parMem  [WAYS][SETS];
  logic [SETS-1:0]      validMem [WAYS];

  always_ff @(posedge clk) begin
    if (ctl.write) begin
      dataMem[wrWay][wrIndex] <= wrLine;
      tagMem[wrWay][wrIndex]  <= wrTag;
      parMem[wrWay][wrIndex]  <= wrParity;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) validMem[w] <= '0;
    end else if (ctl.write) begin
      validMem[wrWay][wrIndex] <= 1'b1;
    end
  end

  // port 0: addressed line, port 1: following line (wraps sets, carries into tag)
  logic [1:0][LA_W-1:0]      portAddr;
  logic [1:0]                portHit;
  logic [1:0][LINE_BITS-1:0] portData;
  logic [1:0][GROUPS-1:0]    portPar;

  assign portAddr[0] = lineAddr;
  assign portAddr[1] = lineAddr + LA_W'(1);

  for (genvar p = 0; p < 2; p++) begin : gPort
    logic [IDX_W-1:0]                idx;
    logic [TAG_W-1:0]                tag;
    logic [WAYS-1:0]                 wv;
    logic [WAYS-1:0][TAG_W-1:0]      wt;
    logic [WAYS-1:0][LINE_BITS-1:0]  wl;
    logic [WAYS-1:0][GROUPS-1:0]     wp;

    assign idx = portAddr[p][IDX_W-1:0];
    assign tag = portAddr[p][LA_W-1:IDX_W];

    always_comb begin
      for (int w = 0; w < WAYS; w++) begin
        wv[w] = validMem[w][idx];
        wt[w] = tagMem[w][idx];
        wl[w] = dataMem[w][idx];
        wp[w] = parMem[w][idx];
      end
    end

    ifa_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .clk     (clk),
      .rstN    (rstN),
      .wayValid(wv),
      .wayTag  (wt),
      .tagIn   (tag),
      .wayLine (wl),
      .wayPar  (wp),
      .hit     (portHit[p]),
      .line    (portData[p]),
      .par     (portPar[p])
    );
  end

  logic [LINE_BITS-1:0] merged;
  logic [GROUPS-1:0]    mergedPar;
  logic [GROUPS-1:0]    badGroup;
  logic [WIN_BITS-1:0]  winBytes;
  logic                 allHit;

  always_comb begin
    if (ctl.split) begin
      merged    = {portData[1][WIN_BITS-1:0], portData[0][LINE_BITS-1:WIN_BITS]};
      mergedPar = {portPar[1][HALF_GROUPS-1:0], portPar[0][GROUPS-1:HALF_GROUPS]};
    end else begin
      merged    = portData[0];
      mergedPar = portPar[0];
    end
    badGroup = (groupParity(merged) ^ mergedPar) & ctl.groupUse;
    winBytes = merged[{ctl.rot, 3'b000} +: WIN_BITS];
    allHit   = portHit[0] && (!ctl.split || portHit[1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchBytes  <= '0;
      fetchValid  <= 1'b0;
      missN       <= 1'b0;
      missN1      <= 1'b0;
      parityError <= 1'b0;
      splitAccess <= 1'b0;
    end else if (ctl.capture) begin
      fetchBytes  <= winBytes;
      fetchValid  <= allHit && !(|badGroup);
      missN       <= !portHit[0];
      missN1      <= ctl.split && !portHit[1];
      parityError <= allHit && (|badGroup);
      splitAccess <= ctl.split;
    end
  end

  assert_clean_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> !(missN || missN1 || parityError))
    else $error("valid window reported together with a fault");
endmodule

// File: rtl/ifa_split_fetch.sv
module ifa_split_fetch
  import ifa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128,
  parameter int WAYS   = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchReq,
  input  logic [ADDR_W-1:0]    fetchAddr,
  input  logic                 wrEn,
  input  logic [WAY_W-1:0]     wrWay,
  input  logic [IDX_W-1:0]     wrIndex,
  input  logic [TAG_W-1:0]     wrTag,
  input  logic [LINE_BITS-1:0] wrLine,
  input  logic [GROUPS-1:0]    wrParity,
  output logic                 respValid,
  output logic                 fetchValid,
  output logic                 missN,
  output logic                 missN1,
  output logic                 parityError,
  output logic                 splitAccess,
  output logic [WIN_BITS-1:0]  fetchBytes
);
  ifaCtl_t ctl;

  ifa_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchReq   (fetchReq),
    .fetchOffset(fetchAddr[OFF_W-1:0]),
    .wrEn       (wrEn),
    .ctl        (ctl),
    .respValid  (respValid)
  );

  ifa_datapath #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .lineAddr   (fetchAddr[ADDR_W-1:OFF_W]),
    .wrWay      (wrWay),
    .wrIndex    (wrIndex),
    .wrTag      (wrTag),
    .wrLine     (wrLine),
    .wrParity   (wrParity),
    .fetchBytes (fetchBytes),
    .fetchValid (fetchValid),
    .missN      (missN),
    .missN1     (missN1),
    .parityError(parityError),
    .splitAccess(splitAccess)
  );

  assert_split_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> (splitAccess == $past(fetchAddr[OFF_W-1])))
    else $error("split flag disagrees with the requested offset");

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq |=> ($stable(fetchBytes) && !respValid))
    else $error("response changed without a request");
endmodule

// File: tb/ifa_split_fetch_tb_top.sv
module ifa_split_fetch_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         fetchReq = 1'b0;
  logic [31:0]  fetchAddr = '0;
  logic         wrEn = 1'b0;
  logic [0:0]   wrWay = '0;
  logic [6:0]   wrIndex = '0;
  logic [19:0]  wrTag = '0;
  logic [255:0] wrLine = '0;
  logic [3:0]   wrParity = '0;
  logic         respValid, fetchValid, missN, missN1, parityError, splitAccess;
  logic [127:0] fetchBytes;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ifa_split_fetch dut_i (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .wrEn(wrEn), .wrWay(wrWay), .wrIndex(wrIndex), .wrTag(wrTag),
    .wrLine(wrLine), .wrParity(wrParity), .respValid(respValid),
    .fetchValid(fetchValid), .missN(missN), .missN1(missN1),
    .parityError(parityError), .splitAccess(splitAccess), .fetchBytes(fetchBytes)
  );

  // content of the byte at line address la, byte position k
  function automatic logic [7:0] patByte(input logic [26:0] la, input int k);
    logic [31:0] t;
    t = {5'b0, la} * 32'd37 + 32'(k) * 32'd11 + 32'd90;
    return t[7:0];
  endfunction

  function automatic logic [255:0] lineOf(input logic [26:0] la);
    logic [255:0] l;
    for (int k = 0; k < 32; k++) l[k*8 +: 8] = patByte(la, k);
    return l;
  endfunction

  function automatic logic [3:0] parOf(input logic [255:0] l);
    logic [3:0] p;
    for (int g = 0; g < 4; g++) begin
      p[g] = 1'b0;
      for (int b = 0; b < 64; b++) p[g] = p[g] ^ l[g*64 + b];
    end
    return p;
  endfunction

  function automatic logic [127:0] expWin(input logic [31:0] a);
    logic [127:0] w;
    logic [31:0] b;
    for (int i = 0; i < 16; i++) begin
      b = a + 32'(i);
      w[i*8 +: 8] = patByte(b[31:5], int'(b[4:0]));
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic loadLine(input logic [31:0] a, input logic w, input logic [3:0] flip);
    @(negedge clk);
    wrEn = 1'b1;
    wrWay = w;
    wrIndex = a[11:5];
    wrTag = a[31:12];
    wrLine = lineOf(a[31:5]);
    wrParity = parOf(lineOf(a[31:5])) ^ flip;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] a);
    @(negedge clk);
    fetchReq = 1'b1;
    fetchAddr = a;
    @(negedge clk);
    fetchReq = 1'b0;
  endtask

  // {req[3:0], addr[31:0], valid, missN, missN1, parityError, split}
  localparam int NVEC = 17;
  localparam logic [40:0] VEC [NVEC] = '{
    {4'd3, 32'h0001_2040, 5'b10000},   // R3 offset 0
    {4'd3, 32'h0001_2047, 5'b10000},   // R3 offset 7
    {4'd3, 32'h0001_204F, 5'b10000},   // R3 offset 15, last non-split
    {4'd9, 32'h0001_2050, 5'b10001},   // R9 R4 offset 16, halves in way 0 and way 1
    {4'd4, 32'h0001_205D, 5'b10001},   // R4 offset 29
    {4'd4, 32'h0001_205F, 5'b10001},   // R4 offset 31
    {4'd5, 32'h0003_4FF3, 5'b10001},   // R5 set 127 -> set 0, tag+1, decoy in way 0
    {4'd7, 32'h0005_6110, 5'b00101},   // R7 next line absent
    {4'd7, 32'h0005_6104, 5'b10000},   // R7 non-split never flags next line
    {4'd7, 32'h0009_0000, 5'b01000},   // R7 addressed line absent
    {4'd7, 32'h0009_001C, 5'b01101},   // R7 both absent
    {4'd8, 32'h0007_8200, 5'b10000},   // R8 corrupt group 3 not delivered
    {4'd8, 32'h0007_8204, 5'b10000},   // R8 groups 0..2 only
    {4'd8, 32'h0007_8209, 5'b00010},   // R8 group 3 delivered
    {4'd8, 32'h0007_8218, 5'b00011},   // R8 split uses group 3 of first line
    {4'd8, 32'h0007_8210, 5'b00011},   // R8 split offset 16 uses groups 2,3
    {4'd6, 32'h0001_2065, 5'b10000}    // R6 clean hit in way 1
  };

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0]  a;
    logic [4:0]   e;
    logic [127:0] snap;
    string        rq;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R2)
    chk(respValid == 1'b0 && fetchValid == 1'b0 && missN == 1'b0 && missN1 == 1'b0 &&
        parityError == 1'b0 && splitAccess == 1'b0, "R2", "reset flags",
        {122'b0, respValid, fetchValid, missN, missN1, parityError, splitAccess}, '0);
    chk(fetchBytes == '0, "R2", "reset bytes", fetchBytes, '0);

    // R1: nothing valid after reset
    fetch(32'h0001_2040);
    chk(missN == 1'b1 && fetchValid == 1'b0, "R1", "miss after reset",
        {126'b0, missN, fetchValid}, 128'd2);

    loadLine(32'h0001_2040, 1'b0, 4'b0000);
    loadLine(32'h0001_2060, 1'b1, 4'b0000);
    loadLine(32'h0003_4FE0, 1'b1, 4'b0000);
    loadLine(32'h0003_4000, 1'b0, 4'b0000);
    loadLine(32'h0003_5000, 1'b1, 4'b0000);
    loadLine(32'h0005_6100, 1'b0, 4'b0000);
    loadLine(32'h0007_8200, 1'b0, 4'b1000);
    loadLine(32'h0007_8220, 1'b1, 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      a  = VEC[i][36:5];
      e  = VEC[i][4:0];
      rq = $sformatf("R%0d", VEC[i][40:37]);
      fetch(a);
      chk(respValid == 1'b1, "R2", "respValid pulse", {127'b0, respValid}, 128'd1);
      chk(fetchValid == e[4], rq, "fetchValid", {127'b0, fetchValid}, {127'b0, e[4]});
      chk(missN == e[3], rq, "missN", {127'b0, missN}, {127'b0, e[3]});
      chk(missN1 == e[2], rq, "missN1", {127'b0, missN1}, {127'b0, e[2]});
      chk(parityError == e[1], rq, "parityError", {127'b0, parityError}, {127'b0, e[1]});
      chk(splitAccess == e[0], rq, "splitAccess", {127'b0, splitAccess}, {127'b0, e[0]});
      if (e[4]) chk(fetchBytes == expWin(a), rq, "window bytes", fetchBytes, expWin(a));
    end

    // R2: outputs hold across idle cycles and a write
    fetch(32'h0001_2043);
    snap = fetchBytes;
    chk(snap == expWin(32'h0001_2043), "R3", "window before hold", snap, expWin(32'h0001_2043));
    loadLine(32'h0009_9040, 1'b0, 4'b0000);
    repeat (2) @(negedge clk);
    chk(respValid == 1'b0, "R2", "no pulse while idle", {127'b0, respValid}, '0);
    chk(fetchBytes == snap, "R2", "bytes held", fetchBytes, snap);

    // R1: the write above replaced way 0 of set 2
    fetch(32'h0001_2040);
    chk(missN == 1'b1 && fetchValid == 1'b0, "R1", "replaced line misses",
        {126'b0, missN, fetchValid}, 128'd2);
    fetch(32'h0009_9045);
    chk(fetchValid == 1'b1, "R1", "new line hits", {127'b0, fetchValid}, 128'd1);
    chk(fetchBytes == expWin(32'h0009_9045), "R1", "new line bytes",
        fetchBytes, expWin(32'h0009_9045));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule